// File: doc/BRIEF.md
# Three-Level Radix Page Table Walker

This block turns a 64-bit virtual address into a physical address by walking a three-level radix page table held in memory. Each request carries a virtual address, an access kind (read, write or execute) and a user-mode flag. The walker picks the 9-bit index for the current level and fetches one 8-byte entry per level over a memory read port. It then decodes the entry as a pointer to the next table or as a leaf. The result comes back on a one-cycle `done` pulse. That result is either a physical address with the leaf's low flag bits, or a page fault.

A translation control word supplies two things: the root table's page number (bits 43:0) and a mode field (bits 63:60). When the mode field does not select paged translation, the address passes straight through. A leaf found above the bottom level maps a large page: its lower page-number fields must be zero, and the matching virtual index bits take their place.

The request side is a valid/ready stream. `req_ready` is high only while the walker is idle, and the request is taken on the first edge where `req_valid` and `req_ready` are both high. A request that is not accepted may be held or changed freely. On the memory side, `mem_req_valid` is held with a constant address until `mem_req_ready` is seen. At most one read is outstanding. Responses have no back-pressure, and the memory must return exactly one `mem_rsp_valid` beat for each accepted read.

Top module: `pt_walk_top`

## Requirements
- R1: After reset, `req_ready` is 1, while `mem_req_valid` and `done` are 0.
- R2: `req_ready` is high only while idle, so it is 0 in the cycle after a request is accepted. `done` is high for exactly one cycle per accepted request.
- R3: If control bits 63:60 are not 8, the request finishes with no memory read. It returns fault 0, flags 0, and a physical address equal to virtual address bits 55:0.
- R4: With translation on, virtual address bits 63:39 must all equal bit 38. Otherwise the request ends in a fault with no memory read.
- R5: Reads go in level order 2, 1, 0. Each read address is the table base plus index×8, where the index is VA[38:30], VA[29:21] or VA[20:12]. The root base is control bits 43:0 shifted left by 12.
- R6: `mem_req_valid` with its address stays stable until `mem_req_ready`, and no new read is issued before the previous response arrives.
- R7: An entry with bit 0 (valid) clear ends the walk with a fault.
- R8: A valid entry with bits 3:1 all zero is a pointer, and the next base is entry bits 53:10 shifted left by 12. A pointer at level 0 is a fault.
- R9: A valid entry with bit 2 set and bit 1 clear is a fault.
- R10: A level-0 leaf gives physical address {entry[53:10], VA[11:0]} and reports flags entry[4:0]. Every fault reports address 0 and flags 0.
- R11: A leaf at level 1 needs entry bits 18:10 zero, and its address is {entry[53:19], VA[20:12], VA[11:0]}. A leaf at level 2 needs entry bits 27:10 zero, and its address is {entry[53:28], VA[29:12], VA[11:0]}. If the required bits are not zero, the walk faults.
- R12: Access code 0 needs bit 1, code 1 needs bit 2 and code 2 needs bit 3. Code 3 always faults. A user-mode access to a leaf with bit 4 clear faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | Access made in user mode |
| xlat_ctrl | input | 64 | Mode in bits 63:60, root page number in bits 43:0, sampled at accept |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry value |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Page fault |
| done_paddr | output | 56 | Physical address |
| done_perm | output | 5 | Leaf flags, entry bits 4:0 |

## Verification
The bench uses the default parameters: three levels, 9-bit indices, 12-bit offsets and a 56-bit physical address. These reach both large-page sizes, the 2 MiB leaf at level 1 and the 1 GiB leaf at level 2. They also reach the sign-extension rule around bit 38, with the top-level index 257 exercised from the negative half of the space. The memory model runs once with immediate ready and response. It runs again with ready dropped every third cycle and a three-cycle response delay, which exercises the hold rule on the read port across several levels.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // entry flag bit positions
  localparam int FLG_V = 0;
  localparam int FLG_R = 1;
  localparam int FLG_W = 2;
  localparam int FLG_X = 3;
  localparam int FLG_U = 4;
  localparam int FLG_N = 5;
  localparam int PPN_LSB = 10;
  localparam int PTE_SH = 3;
  localparam logic [3:0] MODE_PAGED = 4'd8;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ASK,
    ST_WAIT,
    ST_FIN
  } walk_state_t;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LVL_W  = 2
) (
  input  logic [63:0]      va,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx,
  output logic             canonical
);
  localparam int VA_TOP = OFF_W + IDX_W * LEVELS - 1;

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (level == LVL_W'(k)) idx = va[OFF_W + k*IDX_W +: IDX_W];
    end
  end

  assign canonical = (va[63:VA_TOP] == {(64-VA_TOP){va[VA_TOP]}});
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 44,
  parameter int LVL_W  = 2,
  localparam int LOWP  = (LEVELS - 1) * IDX_W,
  localparam int LOW_W = OFF_W + LOWP,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] ppn,
  input  logic [FLG_N-1:0] flags,
  input  logic [LVL_W-1:0] level,
  input  logic [LOW_W-1:0] va_low,
  input  logic [1:0]       acc,
  input  logic             user,
  output logic             fault,
  output logic             descend,
  output logic [PA_W-1:0]  paddr
);
  logic [LOWP-1:0]   low_ppn;
  logic [LEVELS-2:0] misal;
  logic              is_ptr, reserved, perm_ok;

  for (genvar j = 0; j < LEVELS - 1; j++) begin : g_fld
    logic take_va;
    assign take_va = level > LVL_W'(j);
    assign low_ppn[j*IDX_W +: IDX_W] = take_va ? va_low[OFF_W + j*IDX_W +: IDX_W]
                                               : ppn[j*IDX_W +: IDX_W];
    assign misal[j] = take_va && (ppn[j*IDX_W +: IDX_W] != '0);
  end

  always_comb begin
    case (acc)
      ACC_RD:  perm_ok = flags[FLG_R];
      ACC_WR:  perm_ok = flags[FLG_W];
      ACC_EX:  perm_ok = flags[FLG_X];
      default: perm_ok = 1'b0;
    endcase
  end

  assign is_ptr   = ~|flags[FLG_X:FLG_R];
  assign reserved = flags[FLG_W] & ~flags[FLG_R];

  assign fault = ~flags[FLG_V] | reserved
               | (is_ptr & (level == '0))
               | (~is_ptr & ((|misal) | ~perm_ok | (user & ~flags[FLG_U])));
  assign descend = flags[FLG_V] & ~reserved & is_ptr & (level != '0);
  assign paddr = {ppn[PPN_W-1:LOWP], low_ppn, va_low[OFF_W-1:0]};
endmodule

// File: rtl/pt_walk_top.sv
module pt_walk_top
  import ptw_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 56
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic [1:0]      req_acc,
  input  logic            req_user,
  input  logic [63:0]     xlat_ctrl,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done,
  output logic            done_fault,
  output logic [PA_W-1:0] done_paddr,
  output logic [4:0]      done_perm
);
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int VA_TOP = OFF_W + IDX_W * LEVELS - 1;
  localparam int LOW_W  = OFF_W + IDX_W * (LEVELS - 1);

  walk_state_t      state;
  logic [LVL_W-1:0] level;
  logic [PPN_W-1:0] base_ppn;
  logic [63:0]      va_q, va_sel;
  logic [1:0]       acc_q;
  logic             user_q;
  logic             res_fault;
  logic [PA_W-1:0]  res_paddr;
  logic [4:0]       res_perm;

  logic [IDX_W-1:0] cur_idx;
  logic             canon;
  logic             ent_fault, ent_descend;
  logic [PA_W-1:0]  ent_paddr;
  logic [PPN_W-1:0] rsp_ppn;
  logic             unused_bits;

  assign va_sel  = (state == ST_IDLE) ? req_vaddr : va_q;
  assign rsp_ppn = mem_rsp_data[PPN_LSB + PPN_W - 1:PPN_LSB];
  assign unused_bits = ^{mem_rsp_data[63:PPN_LSB + PPN_W], mem_rsp_data[PPN_LSB-1:FLG_N],
                         xlat_ctrl[59:PPN_W]};

  ptw_va_split #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_W(LVL_W)) split_i (
    .va(va_sel), .level(level), .idx(cur_idx), .canonical(canon)
  );

  ptw_entry_eval #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .LVL_W(LVL_W)) eval_i (
    .ppn(rsp_ppn), .flags(mem_rsp_data[FLG_N-1:0]), .level(level), .va_low(va_q[LOW_W-1:0]),
    .acc(acc_q), .user(user_q), .fault(ent_fault), .descend(ent_descend), .paddr(ent_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      level     <= '0;
      base_ppn  <= '0;
      va_q      <= '0;
      acc_q     <= '0;
      user_q    <= 1'b0;
      res_fault <= 1'b0;
      res_paddr <= '0;
      res_perm  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q      <= req_vaddr;
          acc_q     <= req_acc;
          user_q    <= req_user;
          level     <= LVL_W'(LEVELS - 1);
          base_ppn  <= xlat_ctrl[PPN_W-1:0];
          res_fault <= 1'b0;
          res_perm  <= '0;
          res_paddr <= '0;
          if (xlat_ctrl[63:60] != MODE_PAGED) begin
            res_paddr <= req_vaddr[PA_W-1:0];
            state     <= ST_FIN;
          end else if (!canon) begin
            res_fault <= 1'b1;
            state     <= ST_FIN;
          end else begin
            state     <= ST_ASK;
          end
        end
        ST_ASK: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (ent_fault) begin
            res_fault <= 1'b1;
            state     <= ST_FIN;
          end else if (ent_descend) begin
            base_ppn <= rsp_ppn;
            level    <= level - LVL_W'(1);
            state    <= ST_ASK;
          end else begin
            res_paddr <= ent_paddr;
            res_perm  <= mem_rsp_data[4:0];
            state     <= ST_FIN;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_ASK);
  assign mem_req_addr  = {base_ppn, {OFF_W{1'b0}}} + (PA_W'(cur_idx) << PTE_SH);
  assign done          = (state == ST_FIN);
  assign done_fault    = res_fault;
  assign done_paddr    = res_paddr;
  assign done_perm     = res_perm;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R4
  noncanon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (xlat_ctrl[63:60] == MODE_PAGED) &&
    (req_vaddr[63:VA_TOP] != {(64-VA_TOP){req_vaddr[VA_TOP]}})
    |=> done && done_fault && !mem_req_valid);

  // R3
  bare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (xlat_ctrl[63:60] != MODE_PAGED)
    |=> done && !done_fault && (done_paddr == $past(req_vaddr[PA_W-1:0])));

  // R6
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
endmodule

// File: tb/pt_walk_top_tb_top.sv
module pt_walk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rq_valid = 1'b0;
  logic [63:0] rq_va = '0;
  logic [1:0]  rq_acc = '0;
  logic        rq_user = 1'b0;
  logic [63:0] ctrl = '0;
  logic        m_ready = 1'b0;
  logic        m_rsp_valid = 1'b0;
  logic [63:0] m_rsp_data = '0;

  logic        req_ready, mem_req_valid, done, done_fault;
  logic [55:0] mem_req_addr, done_paddr;
  logic [4:0]  done_perm;

  always #10 clk = ~clk;

  pt_walk_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(rq_valid), .req_ready(req_ready), .req_vaddr(rq_va), .req_acc(rq_acc),
    .req_user(rq_user), .xlat_ctrl(ctrl),
    .mem_req_valid(mem_req_valid), .mem_req_ready(m_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(m_rsp_valid), .mem_rsp_data(m_rsp_data),
    .done(done), .done_fault(done_fault), .done_paddr(done_paddr), .done_perm(done_perm)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int done_cnt = 0;
  bit stall_on = 0;
  int lat = 0;

  logic [63:0] pmem [logic [55:0]];
  logic [55:0] exp_q [$];
  bit          exp_flt;
  logic [55:0] exp_pa;
  logic [4:0]  exp_perm;
  string       cur_tag = "R1";

  bit          pend = 0;
  int          pend_cnt = 0;
  logic [55:0] pend_addr = '0;
  bit          prev_v = 0, prev_r = 0, prev_done = 0;
  logic [55:0] prev_a = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [55:0] a);
    return pmem.exists(a) ? pmem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] mkva(input int i2, input int i1, input int i0, input int off);
    return (64'(i2) << 30) | (64'(i1) << 21) | (64'(i0) << 12) | 64'(off);
  endfunction

  function automatic logic [63:0] mkptr(input logic [63:0] ppn);
    return (ppn << 10) | 64'h1;
  endfunction

  function automatic logic [63:0] mkleaf(input logic [63:0] ppn, input logic [7:0] fl);
    return (ppn << 10) | 64'(fl);
  endfunction

  // behavioural reference: builds expected read list and result
  function automatic void ref_walk(input logic [63:0] va, input logic [1:0] acc,
                                   input bit usr, input logic [63:0] ctl);
    logic [63:0] base, e, ppn, a;
    bit ok;
    exp_q.delete();
    exp_flt = 0; exp_pa = '0; exp_perm = '0;
    if (ctl[63:60] != 4'd8) begin exp_pa = va[55:0]; return; end
    if (va[63:38] != {26{va[38]}}) begin exp_flt = 1; return; end
    base = 64'(ctl[43:0]) * 4096;
    for (int lv = 2; lv >= 0; lv--) begin
      a = base + ((va >> (12 + 9*lv)) & 64'd511) * 8;
      exp_q.push_back(a[55:0]);
      e = rd(a[55:0]);
      if (!e[0] || (e[2] && !e[1])) begin exp_flt = 1; return; end
      ppn = (e >> 10) & ((64'd1 << 44) - 1);
      if (e[3:1] == 3'b000) begin
        if (lv == 0) begin exp_flt = 1; return; end
        base = ppn * 4096;
        continue;
      end
      if ((ppn & ((64'd1 << (9*lv)) - 1)) != 0) begin exp_flt = 1; return; end
      ok = (acc == 0) ? e[1] : (acc == 1) ? e[2] : (acc == 2) ? e[3] : 1'b0;
      if (!ok || (usr && !e[4])) begin exp_flt = 1; return; end
      a = (ppn << 12) | (va & ((64'd1 << (12 + 9*lv)) - 1));
      exp_pa = a[55:0];
      exp_perm = e[4:0];
      return;
    end
  endfunction

  // memory model and per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      m_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_cnt == 0) begin
          m_rsp_valid = 1'b1;
          m_rsp_data = rd(pend_addr);
          pend = 0;
        end else pend_cnt--;
      end
      // R6 hold rule
      if (prev_v && !prev_r)
        chk(mem_req_valid && mem_req_addr == prev_a, "R6", "read not held",
            64'(mem_req_addr), 64'(prev_a));
      m_ready = stall_on ? ((cyc % 3) != 0) : 1'b1;
      if (mem_req_valid && (pend || m_rsp_valid))
        chk(0, "R6", "second read outstanding", 64'(mem_req_addr), 0);
      if (mem_req_valid && m_ready) begin
        if (exp_q.size() == 0) chk(0, "R5", "unexpected read", 64'(mem_req_addr), 0);
        else begin
          logic [55:0] ea;
          ea = exp_q.pop_front();
          chk(mem_req_addr == ea, "R5", "entry address", 64'(mem_req_addr), 64'(ea));
        end
        pend = 1; pend_cnt = lat; pend_addr = mem_req_addr;
      end
      prev_v = mem_req_valid; prev_r = m_ready; prev_a = mem_req_addr;
      if (prev_done) chk(!done, "R2", "done longer than one cycle", 64'(done), 0);
      if (done) begin
        chk(done_fault == exp_flt, cur_tag, "fault", 64'(done_fault), 64'(exp_flt));
        chk(done_paddr == exp_pa, cur_tag, "paddr", 64'(done_paddr), 64'(exp_pa));
        chk(done_perm == exp_perm, cur_tag, "perm", 64'(done_perm), 64'(exp_perm));
        chk(exp_q.size() == 0, "R5", "reads missing", 64'(exp_q.size()), 0);
        done_cnt++;
      end
      prev_done = done;
    end
  end

  task automatic run_one(input string tag, input logic [63:0] va, input logic [1:0] acc,
                         input bit usr);
    int n0, t;
    cur_tag = tag;
    ref_walk(va, acc, usr, ctrl);
    n0 = done_cnt;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R2", "ready while idle", 64'(req_ready), 1);
    rq_valid = 1'b1; rq_va = va; rq_acc = acc; rq_user = usr;
    @(negedge clk); #1;
    rq_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready while busy", 64'(req_ready), 0);
    t = 0;
    while (done_cnt == n0 && t < 300) begin @(negedge clk); #1; t++; end
    if (done_cnt == n0) chk(0, tag, "no done", 0, 1);
    @(negedge clk); #1;
  endtask

  localparam logic [63:0] ROOT = 64'h8000_0000;
  localparam logic [63:0] TBL1 = 64'h8000_1000;
  localparam logic [63:0] TBL0 = 64'h8000_2000;

  initial begin
    pmem[56'(ROOT + 1*8)]   = mkptr(64'h80001);
    pmem[56'(ROOT + 257*8)] = mkptr(64'h80001);
    pmem[56'(ROOT + 3*8)]   = mkleaf(64'h40000, 8'h07);
    pmem[56'(ROOT + 4*8)]   = mkleaf(64'h40200, 8'h07);
    pmem[56'(TBL1 + 2*8)]   = mkptr(64'h80002);
    pmem[56'(TBL1 + 5*8)]   = mkleaf(64'h40200, 8'h0B);
    pmem[56'(TBL1 + 6*8)]   = mkleaf(64'h40201, 8'h0B);
    pmem[56'(TBL0 + 3*8)]   = mkleaf(64'h12345, 8'h17);
    pmem[56'(TBL0 + 7*8)]   = mkleaf(64'h11111, 8'h05);
    pmem[56'(TBL0 + 8*8)]   = mkptr(64'h80003);
    pmem[56'(TBL0 + 9*8)]   = mkleaf(64'h22222, 8'h09);

    ctrl = {4'h8, 16'h0, 44'h80000};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", 64'(mem_req_valid), 0);
    chk(done == 1'b0, "R1", "done", 64'(done), 0);

    for (int pass = 0; pass < 2; pass++) begin
      stall_on = (pass == 1);
      lat = (pass == 1) ? 3 : 0;
      run_one("R10", mkva(1, 2, 3, 12'habc), 2'd0, 1'b1);
      run_one("R12", mkva(1, 2, 3, 12'h010), 2'd1, 1'b1);
      run_one("R12", mkva(1, 2, 3, 12'h020), 2'd2, 1'b1);
      run_one("R12", mkva(1, 2, 3, 12'h030), 2'd3, 1'b0);
      run_one("R12", mkva(1, 2, 9, 12'h444), 2'd2, 1'b0);
      run_one("R12", mkva(1, 2, 9, 12'h444), 2'd0, 1'b0);
      run_one("R12", mkva(1, 2, 9, 12'h444), 2'd2, 1'b1);
      run_one("R11", mkva(1, 5, 9'h1ab, 12'h123), 2'd2, 1'b0);
      run_one("R11", mkva(1, 5, 9'h1ab, 12'h123), 2'd2, 1'b1);
      run_one("R11", mkva(1, 6, 9'h1ab, 12'h123), 2'd0, 1'b0);
      run_one("R11", mkva(3, 9'h55, 9'h77, 12'h009), 2'd1, 1'b0);
      run_one("R11", mkva(4, 9'h55, 9'h77, 12'h009), 2'd0, 1'b0);
      run_one("R7",  mkva(0, 1, 1, 12'h000), 2'd0, 1'b0);
      run_one("R7",  mkva(1, 2, 4, 12'h008), 2'd0, 1'b0);
      run_one("R9",  mkva(1, 2, 7, 12'h000), 2'd1, 1'b0);
      run_one("R8",  mkva(1, 2, 8, 12'h000), 2'd0, 1'b0);
      run_one("R4",  mkva(1, 2, 3, 12'h000) | (64'd1 << 40), 2'd0, 1'b0);
      run_one("R4",  64'hFFFF_FFC0_0000_0000 | mkva(1, 2, 3, 12'h005), 2'd0, 1'b0);
    end

    ctrl = {4'h0, 16'h0, 44'h80000};
    run_one("R3", 64'h1234_5678_9abc_def0, 2'd1, 1'b1);
    ctrl = {4'h9, 16'h0, 44'h80000};
    run_one("R3", 64'h8000_0000_0000_1234, 2'd3, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule